// File: doc/BRIEF.md
# Cacheability Attribute Region Resolver

This block decides, for every CPU access, whether the cache may hold the data, and where an access that the cache must not hold goes. It compares the access address against two size-aligned windows for on-chip memory, one for RAM and one for ROM. It also compares the address against two programmable access-control regions. The checks run in a fixed priority order, and the first source that matches sets the cache mode. When no source matches, a default mode taken from the cache control register applies.

The result is one of three mutually exclusive routes. An access is either cached, or it bypasses the cache to the external bus, or it is an inhibited instruction fetch that may be served through the line-fill buffer. The block has no clock and no state. All outputs follow from the current access attributes and the current register contents. The cache arrays and the register write path live outside this block.

Top module: `cachres_resolver`

## Requirements
- R1: When `ram_valid` is 1 and `addr[31:RAM_SIZE_LOG2]` equals `ram_base[31:RAM_SIZE_LOG2]`, the access is not cacheable, whatever the access-control regions hold (default RAM_SIZE_LOG2 = 12).
- R2: When R1 does not apply, `rom_valid` is 1 and `addr[31:ROM_SIZE_LOG2]` equals `rom_base[31:ROM_SIZE_LOG2]`, the access is not cacheable, whatever the access-control regions hold (default ROM_SIZE_LOG2 = 14).
- R3: When neither window hits and region 0 matches, region 0's mode decides the result even if region 1 also matches.
- R4: When neither window nor region 0 matches and region 1 matches, region 1's mode decides the result.
- R5: A region matches only when its enable bit is 1 and, for every bit i of addr[31:24] whose mask bit is 0, that address bit equals base bit i. Mask bits at 1 are don't-care, and an enable of 0 never matches.
- R6: When no window and no region match, `dflt_mode` decides the result.
- R7: For region and default modes, values 2'b00 and 2'b01 are cacheable, and values 2'b10 and 2'b11 are inhibited.
- R8: When `cpu_space` is 1, the access is never cacheable and never uses the fill buffer. It always bypasses.
- R9: An inhibited write always has `bypass` at 1 and `fill_ok` at 0.
- R10: An inhibited access has `fill_ok` at 1 only when all of these hold: `ifb_en` = 1, `is_write` = 0, `is_instr` = 1, `tt` = 2'b00 and `cpu_space` = 0. Otherwise it has `bypass` at 1.
- R11: Exactly one of `cacheable`, `bypass` and `fill_ok` is 1 for every input combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 32 | Access address |
| is_write | input | 1 | 1 for a write, 0 for a read |
| is_instr | input | 1 | 1 for an instruction fetch |
| tt | input | 2 | Transfer type, 0 = normal |
| cpu_space | input | 1 | CPU-space register access |
| ram_base | input | 32 | On-chip RAM window base |
| ram_valid | input | 1 | RAM window enable |
| rom_base | input | 32 | On-chip ROM window base |
| rom_valid | input | 1 | ROM window enable |
| acr0_base | input | 32 | Region 0 base (bits 31:24 compared) |
| acr0_mask | input | 8 | Region 0 don't-care mask for addr[31:24] |
| acr0_en | input | 1 | Region 0 enable |
| acr0_mode | input | 2 | Region 0 cache mode |
| acr1_base | input | 32 | Region 1 base (bits 31:24 compared) |
| acr1_mask | input | 8 | Region 1 don't-care mask for addr[31:24] |
| acr1_en | input | 1 | Region 1 enable |
| acr1_mode | input | 2 | Region 1 cache mode |
| dflt_mode | input | 2 | Default cache mode |
| ifb_en | input | 1 | Allow inhibited fetches through the fill buffer |
| cacheable | output | 1 | Access may use the cache |
| bypass | output | 1 | Access goes straight to the external bus |
| fill_ok | output | 1 | Inhibited fetch may be served by the fill buffer |

## Verification
The bench sets the sources against each other. A RAM or ROM window hit on top of a cacheable region must stay inhibited. A design with the priority wrong would return the region's cacheable mode. Region 0 and region 1 overlap with opposite modes, so swapping them flips `cacheable`. Masked and disabled regions catch a mask with the wrong polarity, or an enable that is ignored, because either one makes the address fall through to the default mode. The fill-buffer exception is driven with each of its qualifiers missing in turn: non-zero `tt`, a data read, a write and a CPU-space access. A design that drops one qualifier raises `fill_ok` where `bypass` is expected.

// File: rtl/cachres_pkg.sv
package cachres_pkg;

  typedef enum logic [2:0] {
    SRC_RAM  = 3'd0,
    SRC_ROM  = 3'd1,
    SRC_REG0 = 3'd2,
    SRC_REG1 = 3'd3,
    SRC_DFLT = 3'd4
  } src_e;

  // Mode code meaning: upper bit set means inhibited.
  function automatic logic mode_cacheable(input logic [1:0] mode);
    return (mode == 2'b00) || (mode == 2'b01);
  endfunction

  // Size-aligned window compare on the bits above the window size.
  function automatic logic window_hit(input logic [31:0] a, input logic [31:0] base,
                                      input int unsigned size_log2, input logic valid);
    return valid && ((a >> size_log2) == (base >> size_log2));
  endfunction

  // Masked compare of the top address byte; mask bit 1 = don't care.
  function automatic logic region_hit(input logic [7:0] a_top, input logic [7:0] base_top,
                                      input logic [7:0] mask, input logic en);
    return en && (((a_top ^ base_top) & ~mask) == 8'h00);
  endfunction

endpackage

// File: rtl/cr_window_match.sv
module cr_window_match #(
  parameter int unsigned SIZE_LOG2 = 12
) (
  input  logic [31:0] addr,
  input  logic [31:0] base,
  input  logic        valid,
  output logic        hit
);
  import cachres_pkg::*;

  always_comb begin
    hit = window_hit(addr, base, SIZE_LOG2, valid);
  end

  always_comb begin
    if (!valid) a_r1_window_off : assert (!hit);
  end
endmodule

// File: rtl/cr_region_match.sv
module cr_region_match #(
  parameter int N_REG    = 2,
  parameter int MASK_W   = 8,
  localparam int MSB_LSB = 32 - MASK_W
) (
  input  logic [31:0]                addr,
  input  logic [N_REG-1:0][31:0]     base,
  input  logic [N_REG-1:0][MASK_W-1:0] mask,
  input  logic [N_REG-1:0]           en,
  output logic [N_REG-1:0]           hit
);
  import cachres_pkg::*;

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    always_comb begin
      hit[g] = region_hit(addr[31:MSB_LSB], base[g][31:MSB_LSB], mask[g], en[g]);
    end
    always_comb begin
      if (!en[g]) a_r5_disabled_no_hit : assert (!hit[g]);
      if (mask[g] == '1 && en[g]) a_r5_full_mask_hits : assert (hit[g]);
    end
  end
endmodule

// File: rtl/cr_priority.sv
module cr_priority #(
  parameter int N_REG = 2
) (
  input  logic                  ram_hit,
  input  logic                  rom_hit,
  input  logic [N_REG-1:0]      reg_hit,
  input  logic [N_REG-1:0][1:0] reg_mode,
  input  logic [1:0]            dflt_mode,
  output cachres_pkg::src_e     src,
  output logic                  sel_cacheable
);
  import cachres_pkg::*;

  always_comb begin
    src           = SRC_DFLT;
    sel_cacheable = mode_cacheable(dflt_mode);
    if (ram_hit) begin
      src           = SRC_RAM;
      sel_cacheable = 1'b0;
    end else if (rom_hit) begin
      src           = SRC_ROM;
      sel_cacheable = 1'b0;
    end else if (reg_hit[0]) begin
      src           = SRC_REG0;
      sel_cacheable = mode_cacheable(reg_mode[0]);
    end else if (reg_hit[1]) begin
      src           = SRC_REG1;
      sel_cacheable = mode_cacheable(reg_mode[1]);
    end
  end

  always_comb begin
    if (ram_hit) a_r1_ram_first : assert (src == SRC_RAM);
    if (!ram_hit && rom_hit) a_r2_rom_second : assert (src == SRC_ROM);
    if (!ram_hit && !rom_hit && reg_hit[0]) a_r3_reg0_over_reg1 : assert (src == SRC_REG0);
    if (!ram_hit && !rom_hit && (reg_hit == '0)) a_r6_default_used : assert (src == SRC_DFLT);
  end
endmodule

// File: rtl/cr_route.sv
module cr_route (
  input  logic       sel_cacheable,
  input  logic       cpu_space,
  input  logic       is_write,
  input  logic       is_instr,
  input  logic [1:0] tt,
  input  logic       ifb_en,
  output logic       cacheable,
  output logic       bypass,
  output logic       fill_ok
);
  logic inhibited;
  logic fb_qualified;

  always_comb begin
    inhibited    = cpu_space || !sel_cacheable;
    fb_qualified = ifb_en && !is_write && is_instr && (tt == 2'b00) && !cpu_space;
    cacheable    = !inhibited;
    fill_ok      = inhibited && fb_qualified;
    bypass       = inhibited && !fb_qualified;
  end

  always_comb begin
    if (cpu_space) a_r8_cpu_space_bypass : assert (bypass && !cacheable);
    if (is_write && !cacheable) a_r9_write_bypass : assert (bypass && !fill_ok);
    if (fill_ok) a_r10_fill_qual : assert (is_instr && tt == 2'b00 && ifb_en);
  end
endmodule

// File: rtl/cachres_resolver.sv
module cachres_resolver #(
  parameter int unsigned RAM_SIZE_LOG2 = 12,
  parameter int unsigned ROM_SIZE_LOG2 = 14
) (
  input  logic [31:0] addr,
  input  logic        is_write,
  input  logic        is_instr,
  input  logic [1:0]  tt,
  input  logic        cpu_space,
  input  logic [31:0] ram_base,
  input  logic        ram_valid,
  input  logic [31:0] rom_base,
  input  logic        rom_valid,
  input  logic [31:0] acr0_base,
  input  logic [7:0]  acr0_mask,
  input  logic        acr0_en,
  input  logic [1:0]  acr0_mode,
  input  logic [31:0] acr1_base,
  input  logic [7:0]  acr1_mask,
  input  logic        acr1_en,
  input  logic [1:0]  acr1_mode,
  input  logic [1:0]  dflt_mode,
  input  logic        ifb_en,
  output logic        cacheable,
  output logic        bypass,
  output logic        fill_ok
);
  import cachres_pkg::*;

  localparam int N_REG  = 2;
  localparam int MASK_W = 8;

  logic                   ram_hit, rom_hit;
  logic [N_REG-1:0]       reg_hit;
  logic [N_REG-1:0][31:0] reg_base;
  logic [N_REG-1:0][MASK_W-1:0] reg_mask;
  logic [N_REG-1:0]       reg_en;
  logic [N_REG-1:0][1:0]  reg_mode;
  src_e                   src;
  logic                   sel_cacheable;

  always_comb begin
    reg_base = {acr1_base, acr0_base};
    reg_mask = {acr1_mask, acr0_mask};
    reg_en   = {acr1_en, acr0_en};
    reg_mode = {acr1_mode, acr0_mode};
  end

  cr_window_match #(.SIZE_LOG2(RAM_SIZE_LOG2)) u_ram (
    .addr(addr), .base(ram_base), .valid(ram_valid), .hit(ram_hit)
  );

  cr_window_match #(.SIZE_LOG2(ROM_SIZE_LOG2)) u_rom (
    .addr(addr), .base(rom_base), .valid(rom_valid), .hit(rom_hit)
  );

  cr_region_match #(.N_REG(N_REG), .MASK_W(MASK_W)) u_regions (
    .addr(addr), .base(reg_base), .mask(reg_mask), .en(reg_en), .hit(reg_hit)
  );

  cr_priority #(.N_REG(N_REG)) u_prio (
    .ram_hit(ram_hit), .rom_hit(rom_hit), .reg_hit(reg_hit), .reg_mode(reg_mode),
    .dflt_mode(dflt_mode), .src(src), .sel_cacheable(sel_cacheable)
  );

  cr_route u_route (
    .sel_cacheable(sel_cacheable), .cpu_space(cpu_space), .is_write(is_write),
    .is_instr(is_instr), .tt(tt), .ifb_en(ifb_en),
    .cacheable(cacheable), .bypass(bypass), .fill_ok(fill_ok)
  );

  always_comb begin
    a_r11_one_route : assert ($countones({cacheable, bypass, fill_ok}) == 1);
    if (ram_hit || rom_hit) a_r2_window_inhibits : assert (!cacheable);
  end
endmodule

// File: tb/cachres_resolver_test.sv
module cachres_resolver_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] addr, ram_base, rom_base, acr0_base, acr1_base;
  logic is_write, is_instr, cpu_space, ram_valid, rom_valid, acr0_en, acr1_en, ifb_en;
  logic [1:0] tt, acr0_mode, acr1_mode, dflt_mode;
  logic [7:0] acr0_mask, acr1_mask;
  logic cacheable, bypass, fill_ok;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  cachres_resolver uut (
    .addr(addr), .is_write(is_write), .is_instr(is_instr), .tt(tt), .cpu_space(cpu_space),
    .ram_base(ram_base), .ram_valid(ram_valid), .rom_base(rom_base), .rom_valid(rom_valid),
    .acr0_base(acr0_base), .acr0_mask(acr0_mask), .acr0_en(acr0_en), .acr0_mode(acr0_mode),
    .acr1_base(acr1_base), .acr1_mask(acr1_mask), .acr1_en(acr1_en), .acr1_mode(acr1_mode),
    .dflt_mode(dflt_mode), .ifb_en(ifb_en),
    .cacheable(cacheable), .bypass(bypass), .fill_ok(fill_ok)
  );

  // Bench model written per bit rather than by shifting.
  function automatic bit m_inwin(logic [31:0] a, logic [31:0] b, int sz, logic v);
    bit same = 1;
    for (int i = sz; i < 32; i++) if (a[i] != b[i]) same = 0;
    return v && same;
  endfunction

  function automatic bit m_inreg(logic [31:0] a, logic [31:0] b, logic [7:0] m, logic e);
    bit same = 1;
    for (int i = 0; i < 8; i++) if (!m[i] && (a[24+i] != b[24+i])) same = 0;
    return e && same;
  endfunction

  function automatic logic [2:0] model();
    bit inh, fb;
    if (m_inwin(addr, ram_base, 12, ram_valid))      inh = 1;
    else if (m_inwin(addr, rom_base, 14, rom_valid)) inh = 1;
    else if (m_inreg(addr, acr0_base, acr0_mask, acr0_en)) inh = acr0_mode[1];
    else if (m_inreg(addr, acr1_base, acr1_mask, acr1_en)) inh = acr1_mode[1];
    else inh = dflt_mode[1];
    if (cpu_space) inh = 1;
    fb = ifb_en && !is_write && is_instr && (tt == 0) && !cpu_space;
    return {!inh, inh && !fb, inh && fb};
  endfunction

  task automatic chk(string req, logic [2:0] exp);
    #2;
    checks++;
    if ({cacheable, bypass, fill_ok} !== exp) begin
      errors++;
      $display("FAIL %s addr=%h got c/b/f=%b expected %b", req, addr, {cacheable, bypass, fill_ok}, exp);
    end
  endtask

  task automatic base_setup();
    @(negedge clk);
    addr = 32'h0; is_write = 0; is_instr = 1; tt = 0; cpu_space = 0;
    ram_base = 32'h2000_0000; ram_valid = 1;
    rom_base = 32'h3000_0000; rom_valid = 1;
    acr0_base = 32'h4000_0000; acr0_mask = 8'h00; acr0_en = 1; acr0_mode = 2'b10;
    acr1_base = 32'h4000_0000; acr1_mask = 8'h0F; acr1_en = 1; acr1_mode = 2'b00;
    dflt_mode = 2'b01; ifb_en = 1;
  endtask

  initial begin
    base_setup();
    is_instr = 0;
    addr = 32'h9000_0000;
    chk("R6 default cacheable", 3'b100);
    dflt_mode = 2'b11;
    chk("R7 default mode 11 inhibited", 3'b010);
    dflt_mode = 2'b00;
    chk("R7 default mode 00 cacheable", 3'b100);
    // R1: RAM window hit overrides a cacheable region covering it.
    acr0_base = 32'h2000_0000; acr0_mode = 2'b00;
    addr = 32'h2000_0FFC;
    chk("R1 RAM hit inhibits", 3'b010);
    addr = 32'h2000_1000;
    chk("R1 just past RAM window uses region", 3'b100);
    ram_valid = 0; addr = 32'h2000_0004;
    chk("R1 RAM invalid falls to region", 3'b100);
    // R2
    acr0_base = 32'h3000_0000; addr = 32'h3000_3FF0;
    chk("R2 ROM hit inhibits", 3'b010);
    addr = 32'h3000_4000;
    chk("R2 past ROM window", 3'b100);
    // R3/R4: overlapping regions with opposite modes.
    base_setup(); is_instr = 0;
    addr = 32'h4012_3456;
    chk("R3 region0 wins over region1", 3'b010);
    acr0_en = 0;
    chk("R5 disabled region0 lets region1 decide R4", 3'b100);
    addr = 32'h4F00_0000;
    chk("R5 region1 mask don't-care bits", 3'b100);
    addr = 32'h5000_0000;
    chk("R5 mask 0 bits must match, default R6", 3'b100);
    acr1_en = 0; addr = 32'h4000_0000; dflt_mode = 2'b10;
    chk("R5 both disabled gives default", 3'b010);
    // R8
    base_setup(); addr = 32'h9000_0000; cpu_space = 1;
    chk("R8 cpu space never cacheable", 3'b010);
    // R9 / R10
    cpu_space = 0; dflt_mode = 2'b10;
    chk("R10 qualified inhibited fetch uses fill buffer", 3'b001);
    tt = 2'b01;
    chk("R10 nonzero tt bypasses", 3'b010);
    tt = 0; is_instr = 0;
    chk("R10 data read bypasses", 3'b010);
    is_instr = 1; ifb_en = 0;
    chk("R10 enable off bypasses", 3'b010);
    ifb_en = 1; is_write = 1;
    chk("R9 inhibited write bypasses", 3'b010);
    is_write = 0; dflt_mode = 2'b00;
    chk("R11 cacheable fetch no fill buffer", 3'b100);

    // Constrained random mix, R11 checked on every vector.
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      ram_base = {$urandom} & 32'hFFFF_F000; rom_base = {$urandom} & 32'hFFFF_C000;
      acr0_base = $urandom; acr1_base = $urandom;
      acr0_mask = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
      acr1_mask = 8'($urandom);
      {ram_valid, rom_valid, acr0_en, acr1_en, ifb_en} = 5'($urandom);
      {acr0_mode, acr1_mode, dflt_mode, tt} = 8'($urandom);
      if ($urandom % 2) tt = 0;
      is_write = ($urandom % 4 == 0); is_instr = $urandom % 2;
      cpu_space = ($urandom % 8 == 0);
      case ($urandom % 5)
        0: addr = ram_base | ($urandom & 32'h0000_0FFF);
        1: addr = rom_base | ($urandom & 32'h0000_3FFF);
        2: addr = {acr0_base[31:24], 24'($urandom)};
        3: addr = {acr1_base[31:24], 24'($urandom)};
        default: addr = $urandom;
      endcase
      chk("R11 random vector", model());
    end
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule